// File: doc/BRIEF.md
# Indirect Control-Register Bridge

This block lets a host reach a bank of 28 byte-wide control registers through only two 32-bit words on a simple memory-mapped bus. The first word, the command word, carries a register index, a byte of write data and a write-request bit. The second word, the data word, returns the byte read from the selected register and the current level of the interrupt line from the analog side.

A write is posted. The host sets the request bit, and the bridge commits the byte after a fixed number of cycles. During that time the request bit reads back as 1, and the host polls it. A read is started by rewriting only the index with the request bit clear. The data word then shows the new register byte after a fixed settling delay.

A write request that arrives while the bridge is still busy is discarded and raises a sticky error bit, which the host clears by writing 1 to it. Register 0 is a status location that ignores writes. Indices past the end of the bank read as zero and absorb writes.

Top module: `cdcbr_top`

## Requirements
- R1: After reset every register holds its default byte: index 1 = FC, 2 = 1B, 3 = 20, 5 = 80, 8 = FF, 9 = 1F, 10 = 3F, 12 through 15 = 06, 21 = 34, 22 = 07, 23 = 44, 24 = 1F, every other index = 00. The command word and the data word both read 0 after reset.
- R2: The command word is at byte offset 0x0 and the data word at 0x4. The command word has the following fields: bit 31 is the sticky error, bit 16 is the write request / busy bit, bits 14:8 are the register index and bits 7:0 are the write data. The index and data fields read back the last accepted values. All other bits read 0.
- R3: A command-word write with bit 16 set, made while the bridge is idle, makes bit 16 read 1 for exactly WR_LAT (default 4) cycles after the accepting edge. The register takes the new byte on the edge at which bit 16 returns to 0.
- R4: A command-word write with bit 16 set, made while busy, is dropped: the pending write completes unchanged and bit 31 becomes 1. A command-word write with bit 31 set clears the error, unless the same write is itself dropped.
- R5: A command-word write with bit 16 clear, made while idle, updates the index and data fields and starts a read. Data-word bits 7:0 keep the previous value for RD_LAT-1 (default 5) cycles and show the indexed register from the RD_LAT-th (6th) edge after the write.
- R6: Register 0 ignores writes and always reads 00. Indices 28 to 127 read 00, and writes to them have no effect.
- R7: Data-word bit 8 shows the interrupt input as sampled one clock earlier. Data-word bits 31:9 read 0.
- R8: Writes to the data word, or to any offset other than 0x0, change no state. Offsets other than 0x0 and 0x4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the bridge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from state) |
| codec_irq | input | 1 | Interrupt level from the register-side logic |

## Verification
On every cycle, the assertions check the following:
- the busy window never exceeds WR_LAT and always closes at exactly WR_LAT;
- a dropped request always leaves the error bit set;
- read data changes only on a capture event;
- a capture of index 0 yields zero;
- the interrupt bit trails its input by one cycle.

Some behaviours can only be shown by the bench's scenarios:
- the reset defaults;
- that the byte committed after a drop is the first one;
- the exact edge at which new read data appears;
- that out-of-range and data-word writes leave everything unchanged.

// File: rtl/cdcbr_pkg.sv
package cdcbr_pkg;
  localparam int NREG   = 28;
  localparam int IDX_W  = 7;
  localparam int BYTE_W = 8;
  localparam int BIT_REQ = 16;
  localparam int BIT_ERR = 31;
  localparam int BIT_IRQ = 8;

  // power-on contents of the internal bank
  function automatic logic [7:0] dflt_val(input int idx);
    case (idx)
      1:  return 8'hFC;
      2:  return 8'h1B;
      3:  return 8'h20;
      5:  return 8'h80;
      8:  return 8'hFF;
      9:  return 8'h1F;
      10: return 8'h3F;
      12, 13, 14, 15: return 8'h06;
      21: return 8'h34;
      22: return 8'h07;
      23: return 8'h44;
      24: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit reg_writable(input int idx);
    return (idx != 0) && (idx < NREG);
  endfunction

  function automatic logic [31:0] pack_cmd(input logic err, input logic busy,
                                           input logic [IDX_W-1:0] idx,
                                           input logic [BYTE_W-1:0] dat);
    logic [31:0] w;
    w = '0;
    w[BIT_ERR] = err;
    w[BIT_REQ] = busy;
    w[14:8]    = idx;
    w[7:0]     = dat;
    return w;
  endfunction

  function automatic logic [31:0] pack_data(input logic irq,
                                            input logic [BYTE_W-1:0] dat);
    logic [31:0] w;
    w = '0;
    w[BIT_IRQ] = irq;
    w[7:0]     = dat;
    return w;
  endfunction
endpackage

// File: rtl/cdcbr_regfile.sv
module cdcbr_regfile
  import cdcbr_pkg::*;
#(
  parameter int N = NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_val
);
  logic [7:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (reg_writable(i)) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[i] <= dflt_val(i);
        else if (wr_en && (int'(wr_idx) == i))
          mem[i] <= wr_val;
      end
    end else begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= dflt_val(i);
        else        mem[i] <= dflt_val(i);
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N; k++)
      if (int'(rd_idx) == k) rd_val = mem[k];
  end
endmodule

// File: rtl/cdcbr_wr_seq.sv
module cdcbr_wr_seq
  import cdcbr_pkg::*;
#(
  parameter int WR_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [7:0]       val_in,
  output logic             busy,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic [7:0]       commit_val
);
  localparam int CW = $clog2(WR_LAT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      commit_idx <= '0;
      commit_val <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q      <= CW'(WR_LAT);
      commit_idx <= idx_in;
      commit_val <= val_in;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CW'(1));
endmodule

// File: rtl/cdcbr_rd_pipe.sv
module cdcbr_rd_pipe
  import cdcbr_pkg::*;
#(
  parameter int RD_LAT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] cap_idx,
  input  logic [7:0]       rd_val,
  output logic             cap_evt,
  output logic [7:0]       data_q
);
  localparam int CW = $clog2(RD_LAT + 1);
  logic [CW-1:0] cnt_q;

  assign cap_evt = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cap_idx <= '0;
      data_q  <= '0;
    end else begin
      if (start) begin
        cnt_q   <= CW'(RD_LAT);
        cap_idx <= idx_in;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (cap_evt) data_q <= rd_val;
    end
  end
endmodule

// File: rtl/cdcbr_top.sv
module cdcbr_top
  import cdcbr_pkg::*;
#(
  parameter int WR_LAT = 4,
  parameter int RD_LAT = 6,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          codec_irq
);
  localparam logic [AW-1:0] OFS_CMD  = AW'(0);
  localparam logic [AW-1:0] OFS_DATA = AW'(4);

  // named internal events
  logic             wr_cmd, accept_wr, accept_rd, drop, clr_err;
  logic             busy, commit;
  logic [IDX_W-1:0] commit_idx, cap_idx, idx_q;
  logic [7:0]       commit_val, dat_q, rd_val, data_q;
  logic             cap_evt, err_q, irq_q;

  assign wr_cmd    = bus_sel && bus_wr && (bus_addr == OFS_CMD);
  assign accept_wr = wr_cmd && bus_wdata[BIT_REQ] && !busy;
  assign accept_rd = wr_cmd && !bus_wdata[BIT_REQ] && !busy;
  assign drop      = wr_cmd && bus_wdata[BIT_REQ] && busy;
  assign clr_err   = wr_cmd && bus_wdata[BIT_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      dat_q <= '0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= codec_irq;
      if (accept_wr || accept_rd) begin
        idx_q <= bus_wdata[14:8];
        dat_q <= bus_wdata[7:0];
      end
      if (drop)         err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  cdcbr_wr_seq #(.WR_LAT(WR_LAT)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(accept_wr),
    .idx_in(bus_wdata[14:8]), .val_in(bus_wdata[7:0]),
    .busy(busy), .commit(commit),
    .commit_idx(commit_idx), .commit_val(commit_val)
  );

  cdcbr_rd_pipe #(.RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(accept_rd),
    .idx_in(bus_wdata[14:8]), .cap_idx(cap_idx),
    .rd_val(rd_val), .cap_evt(cap_evt), .data_q(data_q)
  );

  cdcbr_regfile #(.N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_idx(commit_idx), .wr_val(commit_val),
    .rd_idx(cap_idx), .rd_val(rd_val)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD)
      bus_rdata = pack_cmd(err_q, busy, idx_q, dat_q);
    else if (bus_addr == OFS_DATA)
      bus_rdata = pack_data(irq_q, data_q);
  end
endmodule

// File: rtl/cdcbr_chk.sv
module cdcbr_chk
  import cdcbr_pkg::*;
#(
  parameter int WR_LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             accept_wr,
  input logic             drop,
  input logic             err_q,
  input logic             cap_evt,
  input logic [IDX_W-1:0] cap_idx,
  input logic [7:0]       data_q,
  input logic             codec_irq,
  input logic             irq_q
);
  localparam int CW = $clog2(WR_LAT + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R3: busy window never longer than WR_LAT cycles
  a_r3_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= WR_LAT);
  // R3: busy window closes at exactly WR_LAT cycles
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != '0 && !busy) |-> int'(run_q) == WR_LAT);
  // R3: an accepted write raises busy
  a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_wr |=> busy);
  // R4: a dropped request leaves the error set
  a_r4_drop_err: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_q);
  // R5: read data changes only on a capture
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(data_q));
  // R6: status register reads zero
  a_r6_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_idx == '0) |=> data_q == 8'h00);
  // R7: interrupt bit trails input by one cycle
  a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(codec_irq));
endmodule

bind cdcbr_top cdcbr_chk #(.WR_LAT(WR_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept_wr(accept_wr),
  .drop(drop), .err_q(err_q), .cap_evt(cap_evt), .cap_idx(cap_idx),
  .data_q(data_q), .codec_irq(codec_irq), .irq_q(irq_q)
);

// File: tb/sim_cdcbr_top.sv
module sim_cdcbr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        codec_irq = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cdcbr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .codec_irq(codec_irq)
  );

  // {do_write, index, value, expected}
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 7'd1,   8'h00, 8'hFC},
    {1'b0, 7'd21,  8'h00, 8'h34},
    {1'b1, 7'd3,   8'h5A, 8'h5A},
    {1'b1, 7'd27,  8'hC3, 8'hC3},
    {1'b1, 7'd0,   8'h77, 8'h00},
    {1'b1, 7'd100, 8'h11, 8'h00},
    {1'b0, 7'd8,   8'h00, 8'hFF},
    {1'b1, 7'd13,  8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic reg_write(input logic [6:0] idx, input logic [7:0] v);
    bus_write(4'h0, {15'd0, 1'b1, 1'b0, idx, v});
    repeat (4) @(posedge clk);
  endtask

  task automatic reg_read(input logic [6:0] idx, output logic [7:0] v);
    logic [31:0] w;
    bus_write(4'h0, {15'd0, 1'b0, 1'b0, idx, 8'h00});
    repeat (6) @(posedge clk);
    bus_read(4'h4, w);
    v = w[7:0];
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    // R1: reset state of both words
    bus_read(4'h0, w); chk("R1 cmd word at reset", w, 32'h0);
    bus_read(4'h4, w); chk("R1 data word at reset", w, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // table walk: R1 defaults, R3 writes, R6 read-only and out-of-range
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][23]) reg_write(VEC[i][22:16], VEC[i][15:8]);
      reg_read(VEC[i][22:16], b);
      chk($sformatf("R1/R3/R6 vector %0d", i), {24'd0, b}, {24'd0, VEC[i][7:0]});
    end

    // R2: command word fields read back
    bus_write(4'h0, {15'd0, 1'b0, 1'b0, 7'd9, 8'hA5});
    bus_read(4'h0, w); chk("R2 cmd readback", w, 32'h0000_09A5);
    repeat (6) @(posedge clk);

    // R3: busy lasts exactly four cycles
    bus_write(4'h0, {15'd0, 1'b1, 1'b0, 7'd6, 8'h9C});
    bus_read(4'h0, w); chk("R3 busy after accept", {31'd0, w[16]}, 32'd1);
    repeat (3) @(posedge clk);
    bus_read(4'h0, w); chk("R3 busy at cycle 4", {31'd0, w[16]}, 32'd1);
    @(posedge clk);
    bus_read(4'h0, w); chk("R3 busy cleared", {31'd0, w[16]}, 32'd0);

    // R5: stale data for five cycles, new from the sixth edge
    reg_read(7'd1, b);
    bus_write(4'h0, {15'd0, 1'b0, 1'b0, 7'd6, 8'h00});
    repeat (5) @(posedge clk);
    bus_read(4'h4, w); chk("R5 stale before latency", {24'd0, w[7:0]}, 32'hFC);
    @(posedge clk);
    bus_read(4'h4, w); chk("R5 new after latency", {24'd0, w[7:0]}, 32'h9C);

    // R4: request while busy is dropped, error sticks, write-1 clears
    bus_write(4'h0, {15'd0, 1'b1, 1'b0, 7'd5, 8'hAA});
    bus_write(4'h0, {15'd0, 1'b1, 1'b0, 7'd5, 8'h55});
    bus_read(4'h0, w); chk("R4 error set", {31'd0, w[31]}, 32'd1);
    repeat (4) @(posedge clk);
    reg_read(7'd5, b); chk("R4 first write kept", {24'd0, b}, 32'hAA);
    bus_read(4'h0, w); chk("R4 error sticky", {31'd0, w[31]}, 32'd1);
    bus_write(4'h0, {1'b1, 14'd0, 1'b0, 1'b0, 7'd5, 8'h00});
    bus_read(4'h0, w); chk("R4 error cleared", {31'd0, w[31]}, 32'd0);
    repeat (6) @(posedge clk);

    // R8: data-word and stray-offset writes change nothing
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, {15'd0, 1'b1, 1'b0, 7'd5, 8'h12});
    repeat (5) @(posedge clk);
    reg_read(7'd5, b); chk("R8 reg unchanged", {24'd0, b}, 32'hAA);
    bus_read(4'h8, w); chk("R8 stray offset reads 0", w, 32'h0);
    bus_read(4'h0, w); chk("R8 cmd unaffected", w, 32'h0000_0500);

    // R7: interrupt level on bit 8
    codec_irq = 1'b1;
    repeat (2) @(posedge clk);
    bus_read(4'h4, w); chk("R7 irq high", w, 32'h0000_01AA);
    codec_irq = 1'b0;
    repeat (2) @(posedge clk);
    bus_read(4'h4, w); chk("R7 irq low", w, 32'h0000_00AA);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1ms;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule